// File: doc/BRIEF.md
# Edge-Select External Request Unit

This block watches eight external request pins and turns chosen transitions on them into request flags. Each pin has its own 2-bit mode inside a 16-bit control register. A pin can stay in standard mode, where this path ignores it, or it can raise a request on a rising edge, a falling edge, or either edge.

The pins pass through a two-stage synchronizer. The block then samples them only on cycles where a sampling strobe is high, and it compares each new sample with the one taken before. A transition that matches the line's mode sets a sticky pending flag. A per-line clear input drops that flag.

The pending flags are copied to the request outputs only on a second, slower arbitration strobe. Several edges that fall between two arbitration strobes therefore reach the arbiter as one request. In a typical system the sampling strobe fires every second cycle of the base timing unit and the arbitration strobe every eighth.

Top module: `edge_irq_unit`

## Requirements
- R1: The control register is 16 bits wide. It resets to 0x0000, reads back on `cfg_rdata` the value last written, and a write takes effect on the next clock edge.
- R2: Line n is governed by control bits [2n+1:2n], so line 7 uses bits 15:14 and line 0 uses bits 1:0.
- R3: Mode encodings are 00 for standard mode (never raises a request), 01 for a rising edge (sample 0 then 1), 10 for a falling edge (sample 1 then 0) and 11 for either edge.
- R4: Each pin passes through two synchronizer flops. A new sample is taken only in a cycle with `samp_stb` high, and an edge is a difference between that sample and the previous one. Pin activity between strobes that returns to the old level creates no edge.
- R5: A detected edge sets the line's pending flag. The flag stays set until `req_clr` for that line is high in a cycle with no new edge on the line. An edge and a clear in the same cycle leave the flag set.
- R6: `req_out` changes only on the clock edge that ends a cycle with `arb_stb` high, and it then takes the pending flags. Any number of edges between two arbitration strobes yields one request.
- R7: While a line's field is 00, its pending flag is cleared on the next clock edge and stays clear whatever the pin does.
- R8: After reset, `req_out` and all pending flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read data |
| pin_in | input | 8 | Raw external request pins |
| samp_stb | input | 1 | Sampling strobe |
| arb_stb | input | 1 | Arbitration strobe |
| req_clr | input | 8 | Per-line pending clear |
| req_out | output | 8 | Request flags presented to arbitration |

## Verification
The bench aligns a new edge with a clear in the same cycle. A design that lets the clear win would lose that request and show a zero after the next arbitration strobe. It moves a pin and returns it to its old level while the sampling strobe is low, which catches a design that samples every cycle and reports the pulse.

It also raises a pending flag with no arbitration strobe, to show that a design copying flags every cycle leaks the request early. Two edges on an either-edge line are placed inside one arbitration window, and a design that queued them would show a second request after the clear. Writing a line's field to 00 while its flag is set must drop the flag, so a design that only masks new edges would still report the stale request once the field is re-enabled.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int LINES_DEF  = 8;
    localparam int MODE_W     = 2;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [MODE_W-1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic samp;
        logic pend;
    } line_state_t;

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = ~prev & cur;
        fall = prev & ~cur;
        case (mode)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/edge_irq_cfg.sv
module edge_irq_cfg #(
    parameter int N_LINES = edge_irq_pkg::LINES_DEF,
    localparam int CFG_W  = N_LINES * edge_irq_pkg::MODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int W      = edge_irq_pkg::LINES_DEF,
    parameter int STAGES = edge_irq_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/edge_irq_line.sv
module edge_irq_line
    import edge_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_mode_e mode,
    input  logic       sync_in,
    input  logic       samp_stb,
    input  logic       clr,
    output logic       pend_o
);

    line_state_t st;
    logic        hit;

    assign hit = samp_stb & edge_hit(mode, st.samp, sync_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (samp_stb) begin
                st.samp <= sync_in;
            end
            if (mode == EDGE_OFF) begin
                st.pend <= 1'b0;
            end else if (hit) begin
                st.pend <= 1'b1;
            end else if (clr) begin
                st.pend <= 1'b0;
            end
        end
    end

    assign pend_o = st.pend;

endmodule

// File: rtl/edge_irq_arb.sv
module edge_irq_arb #(
    parameter int N_LINES = edge_irq_pkg::LINES_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arb_stb,
    input  logic [N_LINES-1:0] pend,
    output logic [N_LINES-1:0] req_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_out <= '0;
        end else if (arb_stb) begin
            req_out <= pend;
        end
    end

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import edge_irq_pkg::*;
#(
    parameter int N_LINES = LINES_DEF,
    localparam int CFG_W  = N_LINES * MODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [N_LINES-1:0] pin_in,
    input  logic               samp_stb,
    input  logic               arb_stb,
    input  logic [N_LINES-1:0] req_clr,
    output logic [N_LINES-1:0] req_out
);

    logic [CFG_W-1:0]   cfg_q;
    logic [N_LINES-1:0] pin_sync;
    logic [N_LINES-1:0] pend_q;

    edge_irq_cfg #(.N_LINES(N_LINES)) cfg_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    assign cfg_rdata = cfg_q;

    edge_irq_sync #(.W(N_LINES), .STAGES(SYNC_DEPTH)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        edge_irq_line line_i (
            .clk      (clk),
            .rst      (rst),
            .mode     (edge_mode_e'(cfg_q[MODE_W*i +: MODE_W])),
            .sync_in  (pin_sync[i]),
            .samp_stb (samp_stb),
            .clr      (req_clr[i]),
            .pend_o   (pend_q[i])
        );
    end

    edge_irq_arb #(.N_LINES(N_LINES)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .arb_stb (arb_stb),
        .pend    (pend_q),
        .req_out (req_out)
    );

endmodule

// File: rtl/edge_irq_unit_chk.sv
module edge_irq_unit_chk #(
    parameter int N_LINES = edge_irq_pkg::LINES_DEF,
    localparam int CFG_W  = N_LINES * edge_irq_pkg::MODE_W
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [CFG_W-1:0]   cfg_wdata,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic               samp_stb,
    input logic               arb_stb,
    input logic [N_LINES-1:0] req_out,
    input logic [N_LINES-1:0] pend_q,
    input logic [CFG_W-1:0]   cfg_q
);

    logic [N_LINES-1:0] off_mask;

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            off_mask[i] = (cfg_q[2*i +: 2] == 2'b00);
        end
    end

    assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    assert_pend_only_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
        !samp_stb |=> ((pend_q & ~$past(pend_q)) == '0));

    assert_req_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
        !arb_stb |=> $stable(req_out));

    assert_req_copies_pend_R6: assert property (@(posedge clk) disable iff (rst)
        arb_stb |=> req_out == $past(pend_q));

    assert_off_line_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (off_mask != '0) |=> ((pend_q & $past(off_mask)) == '0));

endmodule

bind edge_irq_unit edge_irq_unit_chk #(.N_LINES(N_LINES)) chk_i (.*);

// File: tb/edge_irq_unit_tb_top.sv
`timescale 1ns/1ps
module edge_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [7:0]  pin_in = '0;
    logic        samp_stb;
    logic        arb_stb;
    logic [7:0]  req_clr = '0;
    logic [7:0]  req_out;

    logic        free_run = 1'b1;
    logic        m_samp = 1'b0;
    logic        m_arb = 1'b0;
    logic [2:0]  fr_cnt = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc_cnt = 0;

    always #4 clk = ~clk;

    always @(negedge clk) fr_cnt <= fr_cnt + 3'd1;

    assign samp_stb = free_run ? fr_cnt[0] : m_samp;
    assign arb_stb  = free_run ? (fr_cnt == 3'd7) : m_arb;

    edge_irq_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_in    (pin_in),
        .samp_stb  (samp_stb),
        .arb_stb   (arb_stb),
        .req_clr   (req_clr),
        .req_out   (req_out)
    );

    // stimulus: control value, pins before, pins after
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 8'h00, 8'hFF},
        {16'h5555, 8'h00, 8'hFF},
        {16'h5555, 8'hFF, 8'h00},
        {16'hAAAA, 8'hFF, 8'h00},
        {16'hAAAA, 8'h00, 8'hFF},
        {16'hFFFF, 8'h0F, 8'hF0},
        {16'h4000, 8'h00, 8'h81},
        {16'h0002, 8'h01, 8'h00},
        {16'h1BE4, 8'h55, 8'hAA}
    };

    function automatic logic [7:0] expect_req(logic [15:0] cfg, logic [7:0] b, logic [7:0] a);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic [1:0] m;
            logic rise, fall;
            m = cfg[2*i +: 2];
            rise = !b[i] && a[i];
            fall = b[i] && !a[i];
            r[i] = (m == 2'b01 && rise) || (m == 2'b10 && fall) || (m == 2'b11 && (rise || fall));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(input logic s, input logic a, input logic [7:0] c);
        m_samp = s;
        m_arb = a;
        req_clr = c;
        @(negedge clk);
        m_samp = 1'b0;
        m_arb = 1'b0;
        req_clr = '0;
    endtask

    // move pin 0, let it cross the synchronizer, then take one sample
    task automatic pin0_sample(input logic v);
        pin_in[0] = v;
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset req_out", {8'h00, req_out}, 16'h0000);
        check("R1 reset control value", cfg_rdata, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] cfg;
            logic [7:0]  b, a;
            {cfg, b, a} = VEC[v];
            write_cfg(cfg);
            check("R1 readback", cfg_rdata, cfg);
            pin_in = b;
            wait_cyc(24);
            req_clr = 8'hFF;
            @(negedge clk);
            req_clr = '0;
            wait_cyc(12);
            check("R5 cleared before vector", {8'h00, req_out}, 16'h0000);
            pin_in = a;
            wait_cyc(24);
            check("R2/R3 edge modes", {8'h00, req_out}, {8'h00, expect_req(cfg, b, a)});
        end

        // directed tests with manual strobes
        free_run = 1'b0;
        write_cfg(16'h0001);
        pin0_sample(1'b0);
        step(1'b0, 1'b0, 8'hFF);
        step(1'b0, 1'b1, 8'h00);
        check("R5 start clear", {8'h00, req_out}, 16'h0000);
        pin_in[0] = 1'b1;
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h01);
        step(1'b0, 1'b1, 8'h00);
        check("R5 edge beats clear", {8'h00, req_out}, 16'h0001);
        step(1'b0, 1'b0, 8'h01);
        step(1'b0, 1'b1, 8'h00);
        check("R5 clear drops flag", {8'h00, req_out}, 16'h0000);

        // R4: pulse with no sampling strobe is invisible
        pin_in[0] = 1'b0;
        wait_cyc(4);
        pin_in[0] = 1'b1;
        wait_cyc(4);
        pin_in[0] = 1'b0;
        wait_cyc(4);
        pin_in[0] = 1'b1;
        wait_cyc(4);
        step(1'b0, 1'b1, 8'h00);
        check("R4 no sample no edge", {8'h00, req_out}, 16'h0000);
        pin0_sample(1'b0);
        pin0_sample(1'b1);
        step(1'b0, 1'b1, 8'h00);
        check("R4 sampled rising edge", {8'h00, req_out}, 16'h0001);

        // R6: output moves only with arbitration strobe
        step(1'b0, 1'b0, 8'hFF);
        wait_cyc(3);
        check("R6 hold without strobe", {8'h00, req_out}, 16'h0001);
        step(1'b0, 1'b1, 8'h00);
        pin0_sample(1'b0);
        pin0_sample(1'b1);
        wait_cyc(5);
        check("R6 pending not yet presented", {8'h00, req_out}, 16'h0000);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b0, 8'hFF);
        step(1'b0, 1'b1, 8'h00);

        // R6 merge: two edges in one window, one request
        write_cfg(16'h0003);
        pin0_sample(1'b0);
        pin0_sample(1'b1);
        step(1'b0, 1'b1, 8'h00);
        check("R6 merged request", {8'h00, req_out}, 16'h0001);
        step(1'b0, 1'b0, 8'h01);
        step(1'b0, 1'b1, 8'h00);
        check("R6 single request after clear", {8'h00, req_out}, 16'h0000);

        // R7: standard mode drops pending and ignores pin
        pin0_sample(1'b0);
        write_cfg(16'h0000);
        write_cfg(16'h0003);
        step(1'b0, 1'b1, 8'h00);
        check("R7 disable drops pending", {8'h00, req_out}, 16'h0000);
        write_cfg(16'h0000);
        pin0_sample(1'b1);
        step(1'b0, 1'b1, 8'h00);
        check("R7 edge ignored in standard mode", {8'h00, req_out}, 16'h0000);
        check("R1 readback after writes", cfg_rdata, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule